// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block sits on the receive path of an Ethernet MAC. It watches the first six bytes of each incoming frame, which hold the destination address, and gives a single-cycle verdict saying whether the frame should be kept. Four tests can pass a frame. Two are exact compares against software-programmed unicast addresses. One recognises the broadcast address. The last looks up a 64-entry group hash table.

Software sets up the filter through a small write-only port with 32-bit data and a 3-bit word select. The port holds both unicast addresses, the two halves of the hash table and a control word. The filter copies the whole configuration when a frame's first address byte arrives. A write that lands while an address is being collected therefore only affects later frames. After reset every register is zero, so no frame is accepted until software programs the filter.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, every configuration word is zero, `vd_valid`, `vd_accept`, `vd_hit` and `mac_full_duplex` are low, and a broadcast frame sent before any write is rejected.
- R2: An address starts with a byte that has `rx_valid` and `rx_first` high. It ends with the sixth byte that has `rx_valid` high; idle cycles between bytes are allowed. `vd_valid` is high for exactly the one cycle after the clock edge that takes the sixth byte. Bytes with `rx_valid` high and `rx_first` low are ignored when no address is in progress.
- R3: Unicast slot 0 hits (`vd_hit[0]`) when control bit 0 is set and the address equals slot 0. Address byte k (k = 0 is first on the wire) is bits 8k+7:8k of word 0 for k < 4, and bits 8(k-4)+7:8(k-4) of word 1 for k = 4, 5. Bits 31:16 of word 1 are ignored.
- R4: Unicast slot 1 hits (`vd_hit[1]`) under the same rule, using words 2 and 3 and control bit 1.
- R5: The broadcast test hits (`vd_hit[2]`) when control bit 3 is set and all 48 address bits are one.
- R6: Number the address bits in wire order, so that bit 8k+b is bit b of byte k. The hash index bit m is the XOR of wire bits 6j+m for j = 0..7. An index below 32 selects that bit of word 4; an index of 32 to 63 selects bit (index-32) of word 5. When the selected bit is set, the hash test hits (`vd_hit[3]`).
- R7: The hash test applies only to group addresses (bit 0 of byte 0 set), unless control bit 2 is set, in which case it applies to individual addresses as well.
- R8: `vd_accept` is the OR of the four hit bits, and it is valid only together with `vd_valid`. When `vd_valid` is low, `vd_accept` and `vd_hit` are zero.
- R9: The verdict uses the configuration held at the edge that takes the first address byte. A write in that same cycle, or later in the address, applies only to the next address.
- R10: `mac_full_duplex` equals control bit 7 of word 6, updated one cycle after the write. Writes to other words leave it unchanged.
- R11: A byte with `rx_valid` and `rx_first` high in the middle of an address drops the partial address and starts a new one. Only the new address gets a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Word select: 0/1 slot 0, 2/3 slot 1, 4/5 hash table, 6 control, 7 unused |
| cfg_wr_data | input | 32 | Write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_first | input | 1 | Marks the first destination byte of a frame |
| rx_byte | input | 8 | Receive byte, destination bytes in wire order |
| vd_valid | output | 1 | Verdict strobe |
| vd_accept | output | 1 | Frame accepted |
| vd_hit | output | 4 | Hit detail: [0] slot 0, [1] slot 1, [2] broadcast, [3] hash |
| mac_full_duplex | output | 1 | Full-duplex selection from the control word |

## Verification
Corrupted address storage or a corrupted configuration snapshot shows up only in the hit bits of the next verdict. That verdict appears exactly one cycle after the sixth byte, so the bench compares every output on every cycle against a behavioural model. A byte counter that drifts shows up as a verdict strobe one cycle off, or as an extra or missing strobe. The bench sends addresses with idle gaps, restarted addresses and configuration writes timed against the first byte, so these timing faults are exposed. A wrong hash fold or a swapped half of the table changes the hash hit bit. Group addresses are chosen so that both halves of the table are used.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int REG_W     = 32;
  localparam int DA_BYTES  = 6;
  localparam int DA_W      = DA_BYTES * 8;
  localparam int HASH_W    = 6;
  localparam int HASH_BINS = 1 << HASH_W;
  localparam int N_HIT     = 4;
  localparam int SEL_W     = 3;
  localparam int HI_W      = DA_W - REG_W;

  localparam logic [SEL_W-1:0] SEL_U0_LO  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_U0_HI  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_U1_LO  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_U1_HI  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_TAB_LO = 3'd4;
  localparam logic [SEL_W-1:0] SEL_TAB_HI = 3'd5;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd6;

  localparam int CB_U0       = 0;
  localparam int CB_U1       = 1;
  localparam int CB_HASH_ALL = 2;
  localparam int CB_BCAST    = 3;
  localparam int CB_FDX      = 7;

  localparam int HIT_U0   = 0;
  localparam int HIT_U1   = 1;
  localparam int HIT_BC   = 2;
  localparam int HIT_HASH = 3;

  typedef struct packed {
    logic [DA_W-1:0]      uni0;
    logic [DA_W-1:0]      uni1;
    logic [HASH_BINS-1:0] gtab;
    logic                 en_u0;
    logic                 en_u1;
    logic                 hash_all;
    logic                 en_bc;
  } rxf_cfg_t;
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output rxf_cfg_t         cfg,
  output logic             full_duplex
);
  localparam int N_WORDS = 7;

  logic [N_WORDS-1:0] ld;
  logic [REG_W-1:0]   u0_lo_q, u1_lo_q, tab_lo_q, tab_hi_q;
  logic [HI_W-1:0]    u0_hi_q, u1_hi_q;
  logic               en_u0_q, en_u1_q, hash_all_q, en_bc_q, fdx_q;

  // word-select decode into per-register clock enables
  always_comb begin
    ld = '0;
    if (wr_en) begin
      for (int i = 0; i < N_WORDS; i++) begin
        if (wr_sel == SEL_W'(i)) ld[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u0_lo_q    <= '0;
      u0_hi_q    <= '0;
      u1_lo_q    <= '0;
      u1_hi_q    <= '0;
      tab_lo_q   <= '0;
      tab_hi_q   <= '0;
      en_u0_q    <= 1'b0;
      en_u1_q    <= 1'b0;
      hash_all_q <= 1'b0;
      en_bc_q    <= 1'b0;
      fdx_q      <= 1'b0;
    end else begin
      if (ld[SEL_U0_LO])  u0_lo_q  <= wr_data;
      if (ld[SEL_U0_HI])  u0_hi_q  <= wr_data[HI_W-1:0];
      if (ld[SEL_U1_LO])  u1_lo_q  <= wr_data;
      if (ld[SEL_U1_HI])  u1_hi_q  <= wr_data[HI_W-1:0];
      if (ld[SEL_TAB_LO]) tab_lo_q <= wr_data;
      if (ld[SEL_TAB_HI]) tab_hi_q <= wr_data;
      if (ld[SEL_CTRL]) begin
        en_u0_q    <= wr_data[CB_U0];
        en_u1_q    <= wr_data[CB_U1];
        hash_all_q <= wr_data[CB_HASH_ALL];
        en_bc_q    <= wr_data[CB_BCAST];
        fdx_q      <= wr_data[CB_FDX];
      end
    end
  end

  always_comb begin
    cfg.uni0     = {u0_hi_q, u0_lo_q};
    cfg.uni1     = {u1_hi_q, u1_lo_q};
    cfg.gtab     = {tab_hi_q, tab_lo_q};
    cfg.en_u0    = en_u0_q;
    cfg.en_u1    = en_u1_q;
    cfg.hash_all = hash_all_q;
    cfg.en_bc    = en_bc_q;
  end

  assign full_duplex = fdx_q;
endmodule

// File: rtl/rxf_da_collect.sv
module rxf_da_collect
  import rxf_pkg::*;
#(
  parameter int NBYTES = DA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [7:0]        in_byte,
  input  rxf_cfg_t          cfg_live,
  output logic              last_now,
  output logic [NBYTES*8-1:0] da_now,
  output rxf_cfg_t          cfg_snap
);
  localparam int CNT_W = $clog2(NBYTES + 1);
  localparam int NHOLD = NBYTES - 1;

  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [NHOLD-1:0][7:0]  hold_q;
  logic [NHOLD-1:0]       hold_en;
  logic                   take_first, take_more;
  rxf_cfg_t               snap_q;

  // cnt_q = 0: no address in progress; otherwise bytes already held
  assign take_first = in_valid & in_first;
  assign take_more  = in_valid & ~in_first & (cnt_q != '0);
  assign last_now   = take_more & (cnt_q == CNT_W'(NHOLD));

  always_comb begin
    cnt_d = cnt_q;
    if (take_first)    cnt_d = CNT_W'(1);
    else if (last_now) cnt_d = '0;
    else if (take_more) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NHOLD; i++) begin : g_hold
    if (i == 0) begin : g_first
      assign hold_en[i] = take_first;
    end else begin : g_rest
      assign hold_en[i] = take_more & (cnt_q == CNT_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold_q[i] <= '0;
      else if (hold_en[i]) hold_q[i] <= in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          snap_q <= '0;
    else if (take_first) snap_q <= cfg_live;
  end

  assign da_now   = {in_byte, hold_q};
  assign cfg_snap = snap_q;
endmodule

// File: rtl/rxf_match.sv
module rxf_match
  import rxf_pkg::*;
(
  input  logic [DA_W-1:0]  da,
  input  rxf_cfg_t         cfg,
  output logic [N_HIT-1:0] hit
);
  localparam int NSLICE = DA_W / HASH_W;

  logic [HASH_W-1:0] idx;
  logic              group;

  // fold the wire-ordered address into a bin index
  always_comb begin
    idx = '0;
    for (int j = 0; j < NSLICE; j++) idx ^= da[j*HASH_W +: HASH_W];
  end

  assign group = da[0];

  always_comb begin
    hit           = '0;
    hit[HIT_U0]   = cfg.en_u0 & (da == cfg.uni0);
    hit[HIT_U1]   = cfg.en_u1 & (da == cfg.uni1);
    hit[HIT_BC]   = cfg.en_bc & (&da);
    hit[HIT_HASH] = (group | cfg.hash_all) & cfg.gtab[idx];
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [2:0]       cfg_wr_sel,
  input  logic [31:0]      cfg_wr_data,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic [7:0]       rx_byte,
  output logic             vd_valid,
  output logic             vd_accept,
  output logic [3:0]       vd_hit,
  output logic             mac_full_duplex
);
  logic             rst_sync_n;
  rxf_cfg_t         cfg_live, cfg_snap;
  logic             last_now;
  logic [DA_W-1:0]  da_now;
  logic [N_HIT-1:0] hit_now;

  logic             vd_valid_q, vd_valid_d;
  logic             vd_accept_q, vd_accept_d;
  logic [N_HIT-1:0] vd_hit_q, vd_hit_d;

  rxf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxf_cfg_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (cfg_wr_en),
    .wr_sel      (cfg_wr_sel),
    .wr_data     (cfg_wr_data),
    .cfg         (cfg_live),
    .full_duplex (mac_full_duplex)
  );

  rxf_da_collect #(.NBYTES(DA_BYTES)) u_collect (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (rx_valid),
    .in_first (rx_first),
    .in_byte  (rx_byte),
    .cfg_live (cfg_live),
    .last_now (last_now),
    .da_now   (da_now),
    .cfg_snap (cfg_snap)
  );

  rxf_match u_match (
    .da  (da_now),
    .cfg (cfg_snap),
    .hit (hit_now)
  );

  always_comb begin
    vd_valid_d  = last_now;
    vd_hit_d    = last_now ? hit_now : '0;
    vd_accept_d = last_now & (|hit_now);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vd_valid_q  <= 1'b0;
      vd_accept_q <= 1'b0;
      vd_hit_q    <= '0;
    end else begin
      vd_valid_q  <= vd_valid_d;
      vd_accept_q <= vd_accept_d;
      vd_hit_q    <= vd_hit_d;
    end
  end

  assign vd_valid  = vd_valid_q;
  assign vd_accept = vd_accept_q;
  assign vd_hit    = vd_hit_q;
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [2:0] cfg_wr_sel,
  input logic       wr_fdx_bit,
  input logic       rx_valid,
  input logic       rx_first,
  input logic       vd_valid,
  input logic       vd_accept,
  input logic [3:0] vd_hit,
  input logic       mac_full_duplex
);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |=> !vd_valid);

  assert_valid_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vd_valid |-> $past(rx_valid));

  assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_valid |-> (vd_hit == 4'd0 && !vd_accept));

  assert_duplex_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_sel == rxf_pkg::SEL_CTRL) |=> (mac_full_duplex == $past(wr_fdx_bit)));

  assert_duplex_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr_en && cfg_wr_sel == rxf_pkg::SEL_CTRL) |=> $stable(mac_full_duplex));

  assert_restart_no_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first) |=> !vd_valid);
endmodule

bind rx_dest_filter rxf_filter_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_sync_n),
  .cfg_wr_en       (cfg_wr_en),
  .cfg_wr_sel      (cfg_wr_sel),
  .wr_fdx_bit      (cfg_wr_data[rxf_pkg::CB_FDX]),
  .rx_valid        (rx_valid),
  .rx_first        (rx_first),
  .vd_valid        (vd_valid),
  .vd_accept       (vd_accept),
  .vd_hit          (vd_hit),
  .mac_full_duplex (mac_full_duplex)
);

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [2:0]  cfg_wr_sel;
  logic [31:0] cfg_wr_data;
  logic        rx_valid, rx_first;
  logic [7:0]  rx_byte;
  logic        vd_valid, vd_accept, mac_full_duplex;
  logic [3:0]  vd_hit;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #4 clk = ~clk;

  rx_dest_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .rx_valid(rx_valid), .rx_first(rx_first),
    .rx_byte(rx_byte), .vd_valid(vd_valid), .vd_accept(vd_accept),
    .vd_hit(vd_hit), .mac_full_duplex(mac_full_duplex)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int i = 0; i < 48; i++) h[i % 6] = h[i % 6] ^ a[i];
    return h;
  endfunction

  function automatic logic [3:0] ref_hits(input logic [47:0] a, input logic [31:0] r [7]);
    logic [3:0] h = '0;
    logic [5:0] ix;
    bit tab;
    for (int s = 0; s < 2; s++) begin
      bit same = 1;
      for (int k = 0; k < 6; k++) begin
        logic [7:0] want;
        want = (k < 4) ? r[2*s][8*k +: 8] : r[2*s+1][8*(k-4) +: 8];
        if (a[8*k +: 8] != want) same = 0;
      end
      if (same && r[6][s]) h[s] = 1'b1;
    end
    if (r[6][3] && a == 48'hffff_ffff_ffff) h[2] = 1'b1;
    ix  = ref_hash(a);
    tab = (ix < 32) ? r[4][ix] : r[5][ix - 32];
    if ((a[0] || r[6][2]) && tab) h[3] = 1'b1;
    return h;
  endfunction

  logic [31:0] m_reg [7];
  logic [31:0] snap [7];
  logic [7:0]  q [$];
  bit          m_act;
  logic        exp_valid, exp_acc, exp_fdx;
  logic [3:0]  exp_hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) m_reg[i] = '0;
      q.delete();
      m_act = 0;
      exp_valid = 0; exp_acc = 0; exp_hit = '0; exp_fdx = 0;
    end else begin
      exp_valid = 0; exp_acc = 0; exp_hit = '0;
      if (rx_valid) begin
        if (rx_first) begin
          q.delete();
          q.push_back(rx_byte);
          snap  = m_reg;
          m_act = 1;
        end else if (m_act) begin
          q.push_back(rx_byte);
          if (q.size() == 6) begin
            logic [47:0] a;
            for (int k = 0; k < 6; k++) a[8*k +: 8] = q[k];
            exp_hit   = ref_hits(a, snap);
            exp_acc   = (exp_hit != 0);
            exp_valid = 1;
            m_act     = 0;
          end
        end
      end
      if (cfg_wr_en && cfg_wr_sel < 3'd7) m_reg[cfg_wr_sel] = cfg_wr_data;
      exp_fdx = m_reg[6][7];
    end
  end

  // per-cycle comparison and verdict capture
  int         nverd = 0;
  logic       last_acc;
  logic [3:0] last_hit;

  always @(negedge clk) begin
    if (started) begin
      check(vd_valid === exp_valid, "R2 verdict strobe", vd_valid, exp_valid);
      check(vd_accept === exp_acc, "R8 accept", vd_accept, exp_acc);
      check(vd_hit[0] === exp_hit[0], "R3 slot0 hit", vd_hit[0], exp_hit[0]);
      check(vd_hit[1] === exp_hit[1], "R4 slot1 hit", vd_hit[1], exp_hit[1]);
      check(vd_hit[2] === exp_hit[2], "R5 broadcast hit", vd_hit[2], exp_hit[2]);
      check(vd_hit[3] === exp_hit[3], "R6 hash hit", vd_hit[3], exp_hit[3]);
      check(mac_full_duplex === exp_fdx, "R10 duplex", mac_full_duplex, exp_fdx);
    end
    if (vd_valid === 1'b1) begin
      nverd++;
      last_acc = vd_accept;
      last_hit = vd_hit;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  // wr_at: byte index during which a control write is issued, -1 for none
  task automatic send(input logic [47:0] a, input int gap, input int wr_at, input logic [31:0] wdata);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_first = (k == 0); rx_byte = a[8*k +: 8];
      cfg_wr_en = (k == wr_at); cfg_wr_sel = 3'd6; cfg_wr_data = wdata;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        rx_valid = 0; cfg_wr_en = 0;
      end
    end
    @(negedge clk);
    rx_valid = 0; rx_first = 0; cfg_wr_en = 0;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic expect_v(input int n0, input logic acc, input logic [3:0] hit, input string tag);
    check(nverd == n0 + 1, {tag, " verdict count"}, nverd, n0 + 1);
    check(last_acc === acc, {tag, " accept"}, last_acc, acc);
    check(last_hit === hit, {tag, " hit"}, last_hit, hit);
  endtask

  function automatic logic [47:0] pick_group(input bit want_hi);
    for (int b = 0; b < 256; b++) begin
      logic [47:0] a;
      a = mk(8'h01, 8'h00, 8'h5e, 8'h12, 8'h34, 8'(b));
      if ((ref_hash(a) >= 32) == want_hi) return a;
    end
    return '0;
  endfunction

  task automatic set_bin(input logic [47:0] a);
    logic [5:0] ix;
    ix = ref_hash(a);
    if (ix < 32) begin wr(3'd4, 32'd1 << ix); wr(3'd5, 32'd0); end
    else         begin wr(3'd5, 32'd1 << (ix - 32)); wr(3'd4, 32'd0); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] ua0, ua1, bc, ga, ia;
    int n0;
    rst_n = 0; cfg_wr_en = 0; cfg_wr_sel = '0; cfg_wr_data = '0;
    rx_valid = 0; rx_first = 0; rx_byte = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    check(vd_valid === 1'b0, "R1 valid after reset", vd_valid, 0);
    check(vd_accept === 1'b0 && vd_hit === 4'd0, "R1 accept after reset", {vd_accept, vd_hit}, 0);
    check(mac_full_duplex === 1'b0, "R1 duplex after reset", mac_full_duplex, 0);
    started = 1;

    ua0 = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    ua1 = mk(8'h0a, 8'h0b, 8'h0c, 8'h0d, 8'h0e, 8'h0f);
    bc  = 48'hffff_ffff_ffff;

    n0 = nverd; send(bc, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R1 unprogrammed broadcast");

    // R3: slot 0, upper half of word 1 ignored
    wr(3'd0, 32'h3322_1102); wr(3'd1, 32'hABCD_5544); wr(3'd6, 32'h1);
    n0 = nverd; send(ua0, 0, -1, 0); expect_v(n0, 1, 4'b0001, "R3 slot0 match");
    n0 = nverd; send(ua0 ^ 48'h0100_0000_0000, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R3 last byte differs");

    // R4: slot 1, slot 0 disabled
    wr(3'd2, 32'h0d0c_0b0a); wr(3'd3, 32'h0000_0f0e); wr(3'd6, 32'h2);
    n0 = nverd; send(ua1, 0, -1, 0); expect_v(n0, 1, 4'b0010, "R4 slot1 match");
    n0 = nverd; send(ua0, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R4 slot0 disabled");

    // R5: broadcast
    wr(3'd6, 32'h8);
    n0 = nverd; send(bc, 0, -1, 0); expect_v(n0, 1, 4'b0100, "R5 broadcast");
    n0 = nverd; send(bc ^ 48'h1000_0000_0000, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R5 not all ones");

    // R6: hash in both table halves
    wr(3'd6, 32'h0);
    ga = pick_group(0); set_bin(ga);
    n0 = nverd; send(ga, 0, -1, 0); expect_v(n0, 1, 4'b1000, "R6 low half bin");
    ga = pick_group(1); set_bin(ga);
    n0 = nverd; send(ga, 0, -1, 0); expect_v(n0, 1, 4'b1000, "R6 high half bin");
    wr(3'd5, 32'h0);
    n0 = nverd; send(ga, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R6 bin cleared");

    // R7: individual addresses need control bit 2
    wr(3'd4, 32'hffff_ffff); wr(3'd5, 32'hffff_ffff);
    ia = mk(8'h06, 8'h21, 8'h43, 8'h65, 8'h87, 8'ha9);
    n0 = nverd; send(ia, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R7 individual without bit2");
    wr(3'd6, 32'h4);
    n0 = nverd; send(ia, 0, -1, 0); expect_v(n0, 1, 4'b1000, "R7 individual with bit2");

    // R9: write at first byte and mid-address affects only the next address
    n0 = nverd; send(ia, 0, 0, 32'h0); expect_v(n0, 1, 4'b1000, "R9 write at first byte");
    n0 = nverd; send(ia, 0, -1, 0); expect_v(n0, 0, 4'b0000, "R9 next address");
    n0 = nverd; send(ia, 1, 3, 32'h4); expect_v(n0, 0, 4'b0000, "R9 write mid address");
    n0 = nverd; send(ia, 0, -1, 0); expect_v(n0, 1, 4'b1000, "R9 following address");

    // R11: restart mid-address
    wr(3'd4, 32'h0); wr(3'd5, 32'h0); wr(3'd6, 32'h1);
    n0 = nverd;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_first = (k == 0); rx_byte = 8'hee;
    end
    send(ua0, 0, -1, 0); expect_v(n0, 1, 4'b0001, "R11 restarted address");

    // R2: gaps between bytes, stray bytes ignored
    n0 = nverd; send(ua0, 3, -1, 0); expect_v(n0, 1, 4'b0001, "R2 gapped bytes");
    n0 = nverd;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rx_valid = 1; rx_first = 0; rx_byte = 8'h02;
    end
    @(negedge clk); rx_valid = 0;
    repeat (3) @(negedge clk); #1;
    check(nverd == n0, "R2 stray bytes no verdict", nverd, n0);

    // R10: duplex bit
    wr(3'd6, 32'h80); #1;
    check(mac_full_duplex === 1'b1, "R10 duplex set", mac_full_duplex, 1);
    wr(3'd5, 32'h0); #1;
    check(mac_full_duplex === 1'b1, "R10 other word no effect", mac_full_duplex, 1);
    wr(3'd6, 32'h0); #1;
    check(mac_full_duplex === 1'b0, "R10 duplex clear", mac_full_duplex, 0);

    // randomized traffic, compared cycle by cycle against the model
    wr(3'd2, 32'h0d0c_0b0a); wr(3'd3, 32'h0000_0f0e);
    for (int f = 0; f < 300; f++) begin
      logic [47:0] a;
      int pick;
      if (f % 10 == 0) begin
        wr(3'd4, $urandom); wr(3'd5, $urandom);
        wr(3'd6, $urandom & 32'h8f);
      end
      pick = $urandom_range(0, 3);
      case (pick)
        0: a = ua0;
        1: a = ua1;
        2: a = bc;
        default: a = {$urandom, $urandom} & 48'hffff_ffff_ffff;
      endcase
      send(a, $urandom_range(0, 1), ($urandom_range(0, 7) == 0) ? 0 : -1, $urandom & 32'h8f);
    end

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule